// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is a slave control port. A host uses it to read and write a bank of 8-bit configuration registers over three wires: an active-low select, a serial clock and a single data line. The data line is shared for both directions. Each transfer starts when the select falls and uses sixteen serial clocks. The first eight bits carry an address byte. The last eight bits carry a data byte that the slave either takes in (write) or sends out (read). Bits travel most significant first in both bytes.

The serial signals are brought into a system clock that runs at least eight times faster than the serial clock. Each signal passes through a multi-flop synchroniser, and the serial clock edges are then found in that domain. A completed write shows up on the chip side as a one-cycle strobe with its index and value. Chip-side logic can also look up any register through a registered read port.

The shared line is modelled at the pad boundary as separate input, output and output-enable signals. The enable is raised only while the slave owns the line.

Top module: `tw_reg_slave`

## Requirements
- R1: After reset, `sdo_oe` and `wr_stb` are both 0.
- R2: On each rising serial clock, the slave samples `sdi`. The first byte is the address byte, sent MSB first. Its bit 7 is the direction (1 = read, 0 = write) and its bits 6:0 are the register index. The second byte, also sent MSB first, is the data.
- R3: A write frame of 16 clocks gives exactly one `wr_stb` pulse, one system cycle wide. The pulse carries the index on `wr_addr` and the data byte on `wr_data`, and the register takes that value.
- R4: If the select rises before the 16th rising clock, the frame has no effect: there is no strobe and no register changes.
- R5: In a read frame, after each of the falling clocks that end slots 8 to 15, the slave drives D7 down to D0 of the addressed register on `sdo`. Each bit is valid at the next rising clock.
- R6: `sdo_oe` is 1 only during the eight data slots of a read frame. It stays 0 through the address slots and through all of a write frame.
- R7: `sdo_oe` returns to 0 after the 16th falling clock even when the select stays low. It also returns to 0 within a few system cycles of the select rising partway through the data byte.
- R8: Serial clocks beyond the 16th in a frame are ignored. They cause no extra strobe, no change to the written value and no further drive of `sdo_oe`.
- R9: A high select clears the framing state, so a frame that follows an aborted one is decoded correctly.
- R10: `lookup_data` gives the contents of the register at `lookup_addr`, one system clock after the address is presented.
- R11: A read frame leaves the register bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data line, input side |
| sdo | output | 1 | Serial data line, output side |
| sdo_oe | output | 1 | Output enable for the shared data line |
| wr_stb | output | 1 | One-cycle pulse when a write frame completes |
| wr_addr | output | 7 | Register index of the completed write |
| wr_data | output | 8 | Value of the completed write |
| lookup_addr | input | 7 | Chip-side register index to read |
| lookup_data | output | 8 | Registered contents of `lookup_addr` |

## Verification
The bench targets these corner cases, and each one catches a particular kind of fault:
- **Frames cut short.** The select rises after 12 clocks or after 15 clocks. A design that commits on a partial count would corrupt a register.
- **Frames of 20 clocks.** A design that does not stop counting at sixteen would emit a second strobe or shift the trailing ones into the value.
- **The enable in every slot.** Read and write frames are both checked slot by slot. This catches an enable that leaks into the address byte, an enable driven during writes, and an enable that lingers after the last falling clock.
- **Many values at many indices.** Data patterns are written and then read back. A swapped bit order or a direction-bit slip shows up as a wrong byte, both on the line and on the chip-side port.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = BYTE_W - 1;
  localparam int FRAME_LEN = 2 * BYTE_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int NUM_REGS  = 1 << ADDR_W;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int       STAGES  = 2,
  parameter int       W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= RST_VAL;
    else     stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= RST_VAL;
      else     stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic [AW-1:0] laddr,
  output logic [DW-1:0] ldata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
    ldata <= mem[laddr];
  end
endmodule

// File: rtl/tw_frame.sv
module tw_frame
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam logic [CNT_W-1:0] CNT_ADDR_DONE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST_ADDR = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_LAST      = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_FULL      = CNT_W'(FRAME_LEN);

  logic              sclk_q;
  logic              rise, fall;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-2:0] shreg;
  logic [BYTE_W-1:0] in_byte;
  logic [ADDR_W-1:0] addr_q;
  logic              is_rd;
  logic [1:0]        load_pend;
  logic [BYTE_W-1:0] tx;
  logic              in_data_slot;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk_s;
  end

  assign rise         = sclk_s & ~sclk_q;
  assign fall         = ~sclk_s & sclk_q;
  assign in_byte      = {shreg, sdi_s};
  assign in_data_slot = (cnt >= CNT_ADDR_DONE) && (cnt <= CNT_LAST);
  assign rd_addr      = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      shreg     <= '0;
      addr_q    <= '0;
      is_rd     <= 1'b0;
      load_pend <= '0;
      tx        <= '0;
      sdo       <= 1'b0;
      sdo_oe    <= 1'b0;
      wr_stb    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (cs_s) begin
        cnt       <= '0;
        load_pend <= '0;
        sdo_oe    <= 1'b0;
      end else begin
        load_pend <= {load_pend[0], 1'b0};
        if (load_pend[1]) tx <= rd_data;

        if (rise && cnt != CNT_FULL) begin
          shreg <= in_byte[BYTE_W-2:0];
          cnt   <= cnt + 1'b1;
          if (cnt == CNT_LAST_ADDR) begin
            is_rd        <= shreg[BYTE_W-2];
            addr_q       <= in_byte[ADDR_W-1:0];
            load_pend[0] <= shreg[BYTE_W-2];
          end
          if (cnt == CNT_LAST && !is_rd) begin
            wr_stb  <= 1'b1;
            wr_addr <= addr_q;
            wr_data <= in_byte;
          end
        end

        if (fall) begin
          if (is_rd && in_data_slot) begin
            sdo    <= tx[BYTE_W-1];
            tx     <= {tx[BYTE_W-2:0], 1'b0};
            sdo_oe <= 1'b1;
          end else begin
            sdo_oe <= 1'b0;
          end
        end
      end
    end
  end

  // R3
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  // R4
  wr_full_frame_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (cnt == CNT_FULL && !is_rd));

  // R6
  oe_read_only_chk: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> (is_rd && cnt >= CNT_ADDR_DONE));

  // R7
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !sdo_oe);

  // R8
  bit_cap_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_FULL);

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_FULL && !cs_s) |=> (cnt == CNT_FULL || cs_s));
endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave
  import tw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] lookup_addr,
  output logic [BYTE_W-1:0] lookup_data
);
  localparam int NSIG = 3;

  logic [NSIG-1:0]   pins_raw, pins_s;
  logic [ADDR_W-1:0] rd_addr;
  logic [BYTE_W-1:0] rd_data;

  assign pins_raw = {cs_n, sclk, sdi};

  tw_sync #(
    .STAGES  (SYNC_STAGES),
    .W       (NSIG),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_raw),
    .q   (pins_s)
  );

  tw_frame u_frame (
    .clk     (clk),
    .rst     (rst),
    .cs_s    (pins_s[2]),
    .sclk_s  (pins_s[1]),
    .sdi_s   (pins_s[0]),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  tw_regfile #(
    .AW (ADDR_W),
    .DW (BYTE_W)
  ) u_regs (
    .clk   (clk),
    .we    (wr_stb),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data),
    .laddr (lookup_addr),
    .ldata (lookup_data)
  );
endmodule

// File: tb/tb_tw_reg_slave.sv
`timescale 1ns/1ps
module tb_tw_reg_slave;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic       sdo, sdo_oe, wr_stb;
  logic [6:0] wr_addr, lookup_addr = '0;
  logic [7:0] wr_data, lookup_data;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [14:0] exp_q [$];

  always #2.5 clk = ~clk;

  tw_reg_slave dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .lookup_addr(lookup_addr), .lookup_data(lookup_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Scoreboard monitor: every write strobe must match the oldest expected write (R3),
  // and a strobe with nothing queued means an aborted or read frame had an effect (R4, R8, R11).
  always @(negedge clk) begin
    if (!rst && wr_stb) begin
      if (exp_q.size() == 0) begin
        chk("R4 unexpected write strobe", {17'd0, wr_addr, wr_data}, 32'h7fff_ffff);
      end else begin
        logic [14:0] e;
        e = exp_q.pop_front();
        chk("R3 write strobe addr/data", {17'd0, wr_addr, wr_data}, {17'd0, e});
      end
    end
  end

  // Host-side frame driver. Returns the read-back byte, enable-pattern mismatches,
  // the enable level before the select rises and the level after it rises.
  task automatic frame(input logic [7:0] a, input logic [7:0] d, input int nclk,
                       output logic [7:0] rb, output int oe_bad,
                       output logic oe_tail, output logic oe_after);
    rb = '0;
    oe_bad = 0;
    cs_n = 1'b0;
    cyc(HALF);
    for (int i = 0; i < nclk; i++) begin
      logic exp_oe;
      sdi = (i < 8) ? a[7-i] : ((i < 16) ? d[15-i] : 1'b1);
      cyc(HALF);
      exp_oe = a[7] && (i >= 8) && (i < 16);
      if (sdo_oe !== exp_oe) oe_bad++;
      if (exp_oe) rb[15-i] = sdo;
      sclk = 1'b1;
      cyc(HALF);
      sclk = 1'b0;
    end
    cyc(HALF);
    oe_tail = sdo_oe;
    cs_n = 1'b1;
    cyc(HALF);
    oe_after = sdo_oe;
    cyc(HALF);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, input int nclk);
    logic [7:0] rb;
    int ob;
    logic t, af;
    if (nclk >= 16) exp_q.push_back({a, d});
    frame({1'b0, a}, d, nclk, rb, ob, t, af);
    chk("R6 write frame enable pattern", ob, 0);
  endtask

  task automatic do_read(input string tag, input logic [6:0] a, input logic [7:0] exp, input int nclk);
    logic [7:0] rb;
    int ob;
    logic t, af;
    frame({1'b1, a}, 8'h00, nclk, rb, ob, t, af);
    chk({tag, " R5 read data"}, rb, exp);
    chk("R6 read frame enable pattern", ob, 0);
    chk("R7 enable low after 16th falling clock", t, 0);
    chk("R7 enable low after select high", af, 0);
  endtask

  task automatic lookup(input string tag, input logic [6:0] a, input logic [7:0] exp);
    lookup_addr = a;
    cyc(1);
    chk({tag, " R10 lookup"}, lookup_data, exp);
  endtask

  initial begin
    logic [7:0] rb;
    int ob;
    logic t, af;
    cyc(4);
    rst = 1'b0;
    cyc(2);
    chk("R1 reset sdo_oe", sdo_oe, 0);
    chk("R1 reset wr_stb", wr_stb, 0);

    // R2 R3: writes with distinct bit patterns
    do_write(7'h05, 8'hA5, 16);
    do_write(7'h7F, 8'h3C, 16);
    do_write(7'h00, 8'hFF, 16);
    lookup("R3 reg 05", 7'h05, 8'hA5);
    lookup("R3 reg 7F", 7'h7F, 8'h3C);
    lookup("R3 reg 00", 7'h00, 8'hFF);

    do_read("R2 reg 05", 7'h05, 8'hA5, 16);
    do_read("R2 reg 7F", 7'h7F, 8'h3C, 16);
    do_read("R2 reg 00", 7'h00, 8'hFF, 16);
    lookup("R11 reg 05 after read", 7'h05, 8'hA5);

    // R4: aborted writes after 12 and 15 clocks
    do_write(7'h05, 8'h11, 12);
    lookup("R4 abort at 12", 7'h05, 8'hA5);
    do_write(7'h05, 8'h22, 15);
    lookup("R4 abort at 15", 7'h05, 8'hA5);

    // R9: the frame after an abort decodes correctly
    do_read("R9 after abort", 7'h05, 8'hA5, 16);

    // R7: read aborted in the data byte
    frame({1'b1, 7'h7F}, 8'h00, 12, rb, ob, t, af);
    chk("R6 aborted read enable pattern", ob, 0);
    chk("R7 enable still high mid-data", t, 1);
    chk("R7 enable released by select", af, 0);
    do_read("R9 after read abort", 7'h7F, 8'h3C, 16);

    // R8: extra clocks
    do_write(7'h22, 8'h5A, 20);
    lookup("R8 extra clocks write", 7'h22, 8'h5A);
    do_read("R8 extra clocks read", 7'h22, 8'h5A, 20);

    // R2 R3 R5: data patterns over several indices
    for (int k = 0; k < 8; k++) begin
      logic [6:0] a;
      logic [7:0] d;
      a = 7'(k * 13 + 3);
      d = 8'(k * 37 + 11);
      do_write(a, d, 16);
    end
    for (int k = 0; k < 8; k++) begin
      logic [6:0] a;
      logic [7:0] d;
      a = 7'(k * 13 + 3);
      d = 8'(k * 37 + 11);
      do_read("R5 pattern", a, d, 16);
      lookup("R10 pattern", a, d);
    end

    cyc(20);
    chk("R3 R4 all expected writes seen", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule